// File: doc/BRIEF.md
# SDRAM Request Splitter and Address Decoder

This block sits between an application port and a per-bank SDRAM controller. It accepts a transfer request made of a word address, a length in application (32-bit) words, a read/write flag and a wrap flag. It acknowledges the request, then sends one or more sub-requests downstream. Each sub-request carries the bank, row and column that the block decodes from the linear address. The next sub-request is presented only after the downstream side acknowledges the current one.

When the wrap flag is clear, a request is cut into pieces so that no piece runs past the end of an SDRAM page. The page size follows the run-time column-width setting and memory-bus-width setting. The first piece carries a start marker and the final piece a last marker. A wrap request is not cut: it goes out as one four-word wrapping transfer.

The configuration inputs must be held stable while a request is in progress.

Top module: `sdram_req_splitter`

## Requirements
- R1: After reset, `idle` is 1, `sub_valid` is 0 and `req_ack` is 0 while `req_valid` is 0.
- R2: `req_ack` is 1 in exactly those cycles where `req_valid` is 1 and the block is idle. A request presented while busy is not acknowledged.
- R3: `idle` falls in the cycle after an accepted request with non-zero length. It rises again in the cycle after the final piece is acknowledged. `sub_valid` is never 1 while `idle` is 1.
- R4: A request with `req_wrap`=1 produces exactly one sub-request with `sub_len`=4, `sub_wrap`=1, `sub_start`=1 and `sub_last`=1, whatever its address and length.
- R5: With `req_wrap`=0, each piece length is the smaller of the remaining length and the number of words up to the next page boundary. A page holds 2^(8+cfg_col-S) application words, where S is the width shift of R10. Each following piece starts at the word just after the previous one ends.
- R6: `sub_start` is 1 only on the first piece of a request, and `sub_last` only on its final piece.
- R7: `cfg_col` values 00/01/10/11 select 8/9/10/11 column bits. `sub_col` holds the low column bits of the memory address, zero-extended to 13 bits.
- R8: With `cfg_four_bank`=1, `sub_bank` holds the 2 memory-address bits just above the column. With `cfg_four_bank`=0, `sub_bank[0]` holds the 1 bit just above the column and `sub_bank[1]` is 0.
- R9: `sub_row` holds the 13 memory-address bits just above the bank bits.
- R10: The memory address is the request word address shifted left by S. `cfg_width` 00 (32-bit memory) gives S=0, 01 (16-bit) gives S=1, and 1x (8-bit) gives S=2.
- R11: While `sub_valid` is 1 and `sub_ack` is 0, every `sub_*` field holds its value.
- R12: A request with `req_wrap`=0 and `req_len`=0 is acknowledged and produces no sub-request. `idle` stays 1.
- R13: `sub_write` is the inverse of `req_rd` (`req_rd`=0 means write, 1 means read) on every piece of a request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_col | input | 2 | Column width select (8 to 11 bits) |
| cfg_width | input | 2 | Memory bus width select (00 = 32, 01 = 16, 1x = 8) |
| cfg_four_bank | input | 1 | 1 = four banks, 0 = two banks |
| req_valid | input | 1 | Application request present |
| req_addr | input | ADDR_W | Start word address |
| req_len | input | LEN_W | Length in application words |
| req_rd | input | 1 | 0 = write, 1 = read |
| req_wrap | input | 1 | Four-word wrapping transfer |
| req_ack | output | 1 | Request accepted this cycle |
| sub_valid | output | 1 | Sub-request present |
| sub_ack | input | 1 | Downstream retires the sub-request |
| sub_bank | output | 2 | Decoded bank |
| sub_row | output | 13 | Decoded row |
| sub_col | output | 13 | Decoded column |
| sub_len | output | LEN_W | Piece length in application words |
| sub_write | output | 1 | Piece is a write |
| sub_wrap | output | 1 | Piece is a wrapping transfer |
| sub_start | output | 1 | First piece of the request |
| sub_last | output | 1 | Final piece of the request |
| idle | output | 1 | No request held or being split |

## Verification
The assertions check on every cycle:
- the acknowledge handshake and its link to `idle`;
- that a presented piece holds until it is acknowledged;
- the fixed shape of a wrap piece;
- that the start marker is gone after the first piece;
- that columns stay inside the selected column width;
- that `sub_bank[1]` is clear in two-bank mode.

Only the bench scenarios can show that the pieces add up to the request and break exactly at page boundaries. The same holds for the bank, row and column values decoded for each bus width, column width and bank mode, and for a zero-length request producing nothing.

// File: rtl/sreq_pkg.sv
package sreq_pkg;
    localparam int ROW_W  = 13;
    localparam int COL_W  = 13;
    localparam int BANK_W = 2;
    localparam int WRAP_WORDS = 4;

    // Left shift applied to a word address to get the memory address.
    function automatic logic [1:0] width_shift(input logic [1:0] w);
        case (w)
            2'b00:   return 2'd0;
            2'b01:   return 2'd1;
            default: return 2'd2;
        endcase
    endfunction
endpackage

// File: rtl/sreq_addr_decode.sv
module sreq_addr_decode
    import sreq_pkg::*;
#(
    parameter int ADDR_W = 26
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        cfg_col,
    input  logic [1:0]        cfg_width,
    input  logic              four_bank,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col
);
    localparam int MEM_W = ADDR_W + 2;

    logic [MEM_W-1:0] mem;
    logic [MEM_W-1:0] col_mask;
    logic [MEM_W-1:0] col_full;
    logic [MEM_W-1:0] above;
    logic [MEM_W-1:0] row_src;
    logic [3:0]       col_bits;

    always_comb begin
        mem      = MEM_W'(addr) << width_shift(cfg_width);
        col_bits = 4'd8 + {2'b00, cfg_col};
        col_mask = (MEM_W'(1) << col_bits) - MEM_W'(1);
        col_full = mem & col_mask;
        col      = col_full[COL_W-1:0];
        above    = mem >> col_bits;
        if (four_bank) begin
            bank    = above[1:0];
            row_src = above >> 2;
        end else begin
            bank    = {1'b0, above[0]};
            row_src = above >> 1;
        end
        row = row_src[ROW_W-1:0];
    end
endmodule

// File: rtl/sreq_piece_len.sv
module sreq_piece_len
    import sreq_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int LEN_W  = 9
) (
    input  logic [ADDR_W-1:0] addr,
    input  logic [LEN_W-1:0]  remain,
    input  logic [1:0]        cfg_col,
    input  logic [1:0]        cfg_width,
    input  logic              wrap,
    output logic [LEN_W-1:0]  piece,
    output logic              final_piece
);
    localparam int SPAN_W = 13;
    localparam int CMP_W  = ((SPAN_W > LEN_W) ? SPAN_W : LEN_W) + 1;

    logic [3:0]       page_exp;
    logic [CMP_W-1:0] page;
    logic [CMP_W-1:0] offs;
    logic [CMP_W-1:0] to_end;
    logic [CMP_W-1:0] rem_w;

    always_comb begin
        page_exp = 4'd8 + {2'b00, cfg_col} - {2'b00, width_shift(cfg_width)};
        page     = CMP_W'(1) << page_exp;
        offs     = CMP_W'(addr[11:0]) & (page - CMP_W'(1));
        to_end   = page - offs;
        rem_w    = CMP_W'(remain);
        if (wrap) begin
            piece       = LEN_W'(WRAP_WORDS);
            final_piece = 1'b1;
        end else if (rem_w <= to_end) begin
            piece       = remain;
            final_piece = 1'b1;
        end else begin
            piece       = to_end[LEN_W-1:0];
            final_piece = 1'b0;
        end
    end
endmodule

// File: rtl/sdram_req_splitter.sv
module sdram_req_splitter
    import sreq_pkg::*;
#(
    parameter int ADDR_W = 26,
    parameter int LEN_W  = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_col,
    input  logic [1:0]        cfg_width,
    input  logic              cfg_four_bank,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_rd,
    input  logic              req_wrap,
    output logic              req_ack,
    output logic              sub_valid,
    input  logic              sub_ack,
    output logic [1:0]        sub_bank,
    output logic [12:0]       sub_row,
    output logic [12:0]       sub_col,
    output logic [LEN_W-1:0]  sub_len,
    output logic              sub_write,
    output logic              sub_wrap,
    output logic              sub_start,
    output logic              sub_last,
    output logic              idle
);
    typedef struct packed {
        logic              busy;
        logic [ADDR_W-1:0] addr;
        logic [LEN_W-1:0]  remain;
        logic              first;
        logic              write;
        logic              wrap;
    } split_state_t;

    split_state_t st_d, st_q;
    logic [LEN_W-1:0] piece;
    logic             final_piece;

    sreq_addr_decode #(.ADDR_W(ADDR_W)) i_decode (
        .addr      (st_q.addr),
        .cfg_col   (cfg_col),
        .cfg_width (cfg_width),
        .four_bank (cfg_four_bank),
        .bank      (sub_bank),
        .row       (sub_row),
        .col       (sub_col)
    );

    sreq_piece_len #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_piece (
        .addr        (st_q.addr),
        .remain      (st_q.remain),
        .cfg_col     (cfg_col),
        .cfg_width   (cfg_width),
        .wrap        (st_q.wrap),
        .piece       (piece),
        .final_piece (final_piece)
    );

    always_comb begin
        st_d    = st_q;
        req_ack = req_valid && !st_q.busy;
        if (req_ack) begin
            if (req_len != '0 || req_wrap) begin
                st_d.busy   = 1'b1;
                st_d.addr   = req_addr;
                st_d.remain = req_len;
                st_d.first  = 1'b1;
                st_d.write  = !req_rd;
                st_d.wrap   = req_wrap;
            end
        end else if (st_q.busy && sub_ack) begin
            if (final_piece) begin
                st_d.busy = 1'b0;
            end else begin
                st_d.addr   = st_q.addr + ADDR_W'(piece);
                st_d.remain = st_q.remain - piece;
                st_d.first  = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sub_valid = st_q.busy;
    assign sub_len   = piece;
    assign sub_write = st_q.write;
    assign sub_wrap  = st_q.wrap;
    assign sub_start = st_q.first;
    assign sub_last  = final_piece;
    assign idle      = !st_q.busy;
endmodule

// File: rtl/sreq_checker.sv
module sreq_checker #(
    parameter int ADDR_W = 26,
    parameter int LEN_W  = 9
) (
    input logic              clk,
    input logic              rst_n,
    input logic [1:0]        cfg_col,
    input logic              cfg_four_bank,
    input logic              req_valid,
    input logic              req_ack,
    input logic              sub_valid,
    input logic              sub_ack,
    input logic [1:0]        sub_bank,
    input logic [12:0]       sub_row,
    input logic [12:0]       sub_col,
    input logic [LEN_W-1:0]  sub_len,
    input logic              sub_write,
    input logic              sub_wrap,
    input logic              sub_start,
    input logic              sub_last,
    input logic              idle
);
    a_r2_ack_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        req_ack |-> (idle && req_valid));

    a_r3_idle_no_valid: assert property (@(posedge clk) disable iff (!rst_n)
        idle |-> !sub_valid);

    a_r4_wrap_shape: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_valid && sub_wrap) |-> (sub_start && sub_last && sub_len == LEN_W'(4)));

    a_r5_nonzero_piece: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_valid && !sub_wrap) |-> (sub_len != '0));

    a_r6_start_once: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_valid && sub_ack && !sub_last) |=> (sub_valid && !sub_start));

    a_r7_col_in_range: assert property (@(posedge clk) disable iff (!rst_n)
        sub_valid |-> ((sub_col >> (4'd8 + {2'b00, cfg_col})) == 13'd0));

    a_r8_two_bank: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_valid && !cfg_four_bank) |-> !sub_bank[1]);

    a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_valid && !sub_ack) |=> (sub_valid
            && $stable({sub_bank, sub_row, sub_col, sub_len, sub_write, sub_wrap, sub_start, sub_last})));
endmodule

bind sdram_req_splitter sreq_checker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_chk (.*);

// File: tb/test_sdram_req_splitter.sv
module test_sdram_req_splitter;
    localparam int ADDR_W = 26;
    localparam int LEN_W  = 9;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        cfg_col = 2'b00;
    logic [1:0]        cfg_width = 2'b00;
    logic              cfg_four_bank = 1'b1;
    logic              req_valid = 1'b0;
    logic [ADDR_W-1:0] req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              req_rd = 1'b0;
    logic              req_wrap = 1'b0;
    logic              req_ack;
    logic              sub_valid;
    logic              sub_ack = 1'b0;
    logic [1:0]        sub_bank;
    logic [12:0]       sub_row;
    logic [12:0]       sub_col;
    logic [LEN_W-1:0]  sub_len;
    logic              sub_write;
    logic              sub_wrap;
    logic              sub_start;
    logic              sub_last;
    logic              idle;

    int n_tests = 0;
    int n_fail  = 0;

    always #4 clk = ~clk;

    sdram_req_splitter #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) i_sdram_req_splitter (.*);

    task automatic chk(input logic ok, input string tag, input longint act, input longint exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Drive one request and check every piece; hold = cycles each piece waits for sub_ack.
    task automatic run_req(input longint addr, input int len, input logic rd,
                           input logic wrap, input int hold);
        longint cur, rem, page, offs, piece, mem, cb, above, ebank, erow, ecol, sh;
        int     idx;
        logic   fin;
        sh   = (cfg_width == 2'b00) ? 0 : (cfg_width == 2'b01) ? 1 : 2;
        cb   = 8 + cfg_col;
        page = 1 << (cb - sh);
        @(negedge clk);
        req_addr  = ADDR_W'(addr);
        req_len   = LEN_W'(len);
        req_rd    = rd;
        req_wrap  = wrap;
        req_valid = 1'b1;
        #1;
        chk(req_ack == 1'b1, "R2 ack when idle", req_ack, 1);
        @(negedge clk);
        req_valid = 1'b0;
        if (!wrap && len == 0) begin
            #1;
            chk(idle == 1'b1 && sub_valid == 1'b0, "R12 zero length", sub_valid, 0);
            return;
        end
        chk(idle == 1'b0, "R3 idle falls", idle, 0);
        cur = addr;
        rem = len;
        idx = 0;
        fin = 1'b0;
        while (!fin) begin
            offs = cur % page;
            if (wrap) begin
                piece = 4; fin = 1'b1;
            end else if (rem <= page - offs) begin
                piece = rem; fin = 1'b1;
            end else begin
                piece = page - offs;
            end
            mem   = cur * (1 << sh);
            ecol  = mem % (1 << cb);
            above = mem / (1 << cb);
            if (cfg_four_bank) begin
                ebank = above % 4; erow = (above / 4) % 8192;
            end else begin
                ebank = above % 2; erow = (above / 2) % 8192;
            end
            #1;
            chk(sub_valid == 1'b1, "R3 valid while busy", sub_valid, 1);
            chk(sub_len == LEN_W'(piece), wrap ? "R4 wrap length" : "R5 piece length", sub_len, piece);
            chk(sub_col == 13'(ecol), "R7/R10 column", sub_col, ecol);
            chk(sub_bank == 2'(ebank), "R8 bank", sub_bank, ebank);
            chk(sub_row == 13'(erow), "R9 row", sub_row, erow);
            chk(sub_start == (idx == 0), "R6 start marker", sub_start, idx == 0);
            chk(sub_last == fin, "R6 last marker", sub_last, fin);
            chk(sub_write == !rd, "R13 write flag", sub_write, !rd);
            chk(sub_wrap == wrap, "R4 wrap flag", sub_wrap, wrap);
            for (int h = 0; h < hold; h++) begin
                req_valid = 1'b1;
                @(negedge clk);
                #1;
                chk(req_ack == 1'b0, "R2 no ack while busy", req_ack, 0);
                chk(sub_len == LEN_W'(piece) && sub_col == 13'(ecol) && sub_row == 13'(erow),
                    "R11 held piece", sub_len, piece);
            end
            req_valid = 1'b0;
            sub_ack   = 1'b1;
            @(negedge clk);
            sub_ack = 1'b0;
            cur = cur + piece;
            rem = rem - piece;
            idx++;
        end
        #1;
        chk(idle == 1'b1 && sub_valid == 1'b0, "R3 idle after last", idle, 1);
    endtask

    task automatic t_reset;
        #1;
        chk(idle == 1'b1, "R1 reset idle", idle, 1);
        chk(sub_valid == 1'b0, "R1 reset valid", sub_valid, 0);
        chk(req_ack == 1'b0, "R1 reset ack", req_ack, 0);
    endtask

    task automatic t_no_split;
        cfg_width = 2'b00; cfg_col = 2'b00; cfg_four_bank = 1'b1;
        run_req(64'h0001_2310, 5, 1'b1, 1'b0, 0);
    endtask

    task automatic t_cross_page;
        cfg_width = 2'b00; cfg_col = 2'b00; cfg_four_bank = 1'b1;
        run_req(64'd250, 20, 1'b0, 1'b0, 0);
    endtask

    task automatic t_multi_page_16;
        cfg_width = 2'b01; cfg_col = 2'b01; cfg_four_bank = 1'b1;
        run_req(64'h0034_51F0, 300, 1'b1, 1'b0, 1);
    endtask

    task automatic t_byte_two_bank;
        cfg_width = 2'b10; cfg_col = 2'b11; cfg_four_bank = 1'b0;
        run_req(64'h02AB_CDE0, 511, 1'b0, 1'b0, 0);
    endtask

    task automatic t_wrap;
        cfg_width = 2'b00; cfg_col = 2'b10; cfg_four_bank = 1'b1;
        run_req(64'h0155_53FE, 37, 1'b1, 1'b1, 2);
    endtask

    task automatic t_zero_len;
        cfg_width = 2'b00; cfg_col = 2'b00; cfg_four_bank = 1'b1;
        run_req(64'd12, 0, 1'b0, 1'b0, 0);
    endtask

    task automatic t_hold;
        cfg_width = 2'b11; cfg_col = 2'b00; cfg_four_bank = 1'b0;
        run_req(64'h0000_07C0, 100, 1'b0, 1'b0, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_no_split();
        t_cross_page();
        t_multi_page_16();
        t_byte_two_bank();
        t_wrap();
        t_zero_len();
        t_hold();
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        #800000;
        n_tests++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule